// File: doc/BRIEF.md
# Dual Serial Port Baud and Frame-Flag Control

This block sits beside two enhanced 8051-style serial ports and decides how fast each one shifts and what the top bit of each port's control byte means. Port 0 can be clocked by an overflow tick from Timer 1 or from Timer 2, or by a tick from an independent baud generator. It can also halve that rate. Port 1 always runs from the independent generator at full rate, and uses the same rate for transmit and receive. The block drives one registered baud enable tick per port.

A mode register holds two shared controls. The first is a rate-doubling bit, which affects port 0 only. The second is a flag-view bit. This bit decides whether bit 7 of each port's control byte is the low serial-mode bit or a sticky framing-error flag. The mode bit and the flag are held in separate storage, so changing the view loses neither of them. The flag-view bit, together with the stored mode bit, also tells each receiver to move its receive-interrupt point in modes 2 and 3.

The block also holds the 16-bit reload value and the run bit of the independent generator. The reload value cannot be changed while the generator runs. Software reaches all state through a small byte-wide register window. Writes take effect at a single edge, and read data is registered.

Top module: `uart_baud_frame_ctl`

Register window (3-bit address): 0 = mode register (bit 7 full-rate, bit 6 flag-view, other bits plain storage), 1 = port 0 control byte, 2 = port 1 control byte, 3 = baud config (bits 1:0 port 0 source: 00 Timer 1, 01 Timer 2, 10 or 11 generator; bit 2 generator run; other bits plain storage), 4 = reload low byte, 5 = reload high byte. Addresses 6 and 7 read as 00h, and writes to them are dropped.

## Requirements
- R1: Port 0's tick source is chosen by baud config bits 1:0 (00 Timer 1, 01 Timer 2, 10/11 generator); ticks on the unselected sources never reach baud_tick[0].
- R2: baud_tick[1] follows every generator tick, whatever the full-rate bit and the port 0 source selection hold.
- R3: With the full-rate bit (mode bit 7) at 0, port 0 passes every second selected tick, starting with the second one after reset; with it at 1, every selected tick is passed.
- R4: A write that changes baud config bits 1:0 restarts the port 0 halving phase, so the next selected tick is skipped. The tick that arrives in the cycle of that write is not passed.
- R5: With the flag-view bit (mode bit 6) at 0, bit 7 of each control byte writes and reads the stored serial-mode bit; bits 6:0 are plain storage.
- R6: A framing-error pulse on a port sets that port's sticky flag. With flag-view at 1, bit 7 of the control byte reads the flag. Writing 0 there clears the flag, writing 1 has no effect, and the stored mode bit is left untouched.
- R7: Changing the flag-view bit alters neither the stored mode bit nor the flag of either port.
- R8: ri_late[n] is 1 exactly when flag-view is 1 and port n's stored mode bit is 1 (serial modes 2 and 3).
- R9: Writes to the reload bytes are dropped while the generator run bit (baud config bit 2) is 1; gen_reload and gen_run show the held value.
- R10: A power-on reset loads the mode register with 10h; a system reset without power-on loads 00h; every other register, flag, phase and tick clears on either reset.
- R11: rd_data shows the addressed register one clock after rd_en is sampled; baud ticks appear one clock after the source tick is sampled.
- R12: A framing-error pulse in the same cycle as a clearing write leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, synchronous |
| sys_rst_n | input | 1 | Other system reset, active low, synchronous |
| t1_tick | input | 1 | Timer 1 overflow strobe |
| t2_tick | input | 1 | Timer 2 overflow strobe |
| gen_tick | input | 1 | Independent baud generator strobe |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| fe_pulse | input | 2 | Stop-bit error pulse per receiver |
| baud_tick | output | 2 | Baud enable tick per port |
| ri_late | output | 2 | Per-port move of the receive-interrupt point |
| gen_run | output | 1 | Generator run bit |
| gen_reload | output | 16 | Generator reload value |

## Verification
A register write takes effect at the edge where it is sampled. A read returns data one edge after rd_en, and a baud tick appears one edge after its source strobe. The bench drives every stimulus on a falling edge and samples on the next falling edge, so exactly one rising edge separates cause and effect. Flag effects such as set, clear, view change and the pulse-against-clear race are read back through the register window only after the write that caused them has completed. Tick counts are taken per strobe over several source patterns, so the skip and pass phase is checked at every strobe.

// File: rtl/uart_bfc_pkg.sv
package uart_bfc_pkg;

    localparam int NUM_PORTS = 2;

    typedef enum logic [1:0] {
        SRC_T1      = 2'b00,
        SRC_T2      = 2'b01,
        SRC_GEN     = 2'b10,
        SRC_GEN_ALT = 2'b11
    } baud_src_e;

    typedef enum logic {
        PH_SKIP = 1'b0,
        PH_PASS = 1'b1
    } half_phase_e;

    typedef enum logic {
        FE_CLEAR = 1'b0,
        FE_SET   = 1'b1
    } fe_state_e;

    localparam logic [2:0] REG_MODE  = 3'd0;
    localparam logic [2:0] REG_SC0   = 3'd1;
    localparam logic [2:0] REG_SC1   = 3'd2;
    localparam logic [2:0] REG_BCFG  = 3'd3;
    localparam logic [2:0] REG_RLDLO = 3'd4;
    localparam logic [2:0] REG_RLDHI = 3'd5;

    localparam logic [7:0] MODE_POR_VAL = 8'h10;
    localparam logic [7:0] MODE_SYS_VAL = 8'h00;

endpackage

// File: rtl/bfc_cfg_regs.sv
module bfc_cfg_regs
    import uart_bfc_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8,
    localparam int RLD_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              sys_rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] mode_q,
    output logic [DATA_W-1:0] bcfg_q,
    output logic [RLD_W-1:0]  reload_q,
    output logic              sel_change
);

    logic wr_mode, wr_bcfg, wr_lo, wr_hi;

    always_comb begin
        wr_mode    = wr_en && (addr == ADDR_W'(REG_MODE));
        wr_bcfg    = wr_en && (addr == ADDR_W'(REG_BCFG));
        wr_lo      = wr_en && (addr == ADDR_W'(REG_RLDLO)) && !bcfg_q[2];
        wr_hi      = wr_en && (addr == ADDR_W'(REG_RLDHI)) && !bcfg_q[2];
        sel_change = wr_bcfg && (wr_data[1:0] != bcfg_q[1:0]);
    end

    always_ff @(posedge clk) begin
        if (!por_n) begin
            mode_q <= DATA_W'(MODE_POR_VAL);
        end else if (!sys_rst_n) begin
            mode_q <= DATA_W'(MODE_SYS_VAL);
        end else if (wr_mode) begin
            mode_q <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!por_n || !sys_rst_n) begin
            bcfg_q   <= '0;
            reload_q <= '0;
        end else begin
            if (wr_bcfg) bcfg_q <= wr_data;
            if (wr_lo)   reload_q[DATA_W-1:0] <= wr_data;
            if (wr_hi)   reload_q[RLD_W-1:DATA_W] <= wr_data;
        end
    end

endmodule

// File: rtl/bfc_port0_div.sv
module bfc_port0_div
    import uart_bfc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      t1_tick,
    input  logic      t2_tick,
    input  logic      gen_tick,
    input  baud_src_e sel,
    input  logic      sel_change,
    input  logic      rate_full,
    output logic      tick_q
);

    half_phase_e phase_q, phase_nxt;
    logic        src_hit;
    logic        pass_now;

    always_comb begin
        unique case (sel)
            SRC_T1:      src_hit = t1_tick;
            SRC_T2:      src_hit = t2_tick;
            SRC_GEN,
            SRC_GEN_ALT: src_hit = gen_tick;
        endcase
    end

    always_comb begin
        phase_nxt = phase_q;
        if (sel_change) begin
            phase_nxt = PH_SKIP;
        end else if (src_hit) begin
            unique case (phase_q)
                PH_SKIP: phase_nxt = PH_PASS;
                PH_PASS: phase_nxt = PH_SKIP;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) phase_q <= PH_SKIP;
        else     phase_q <= phase_nxt;
    end

    always_comb begin
        pass_now = src_hit && !sel_change && (rate_full || (phase_q == PH_PASS));
    end

    always_ff @(posedge clk) begin
        if (rst) tick_q <= 1'b0;
        else     tick_q <= pass_now;
    end

endmodule

// File: rtl/bfc_bit7_slot.sv
module bfc_bit7_slot
    import uart_bfc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              fe_view,
    input  logic              fe_pulse,
    output logic [DATA_W-1:0] rd_view,
    output logic              sm0_q,
    output logic              fe_flag
);

    logic [DATA_W-2:0] low_q;
    fe_state_e         fe_q, fe_nxt;
    logic              clear_req;

    always_comb begin
        clear_req = wr && fe_view && !wr_data[DATA_W-1];
        fe_nxt    = fe_q;
        unique case (fe_q)
            FE_CLEAR: if (fe_pulse) fe_nxt = FE_SET;
            FE_SET:   if (!fe_pulse && clear_req) fe_nxt = FE_CLEAR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) fe_q <= FE_CLEAR;
        else     fe_q <= fe_nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            low_q <= '0;
            sm0_q <= 1'b0;
        end else if (wr) begin
            low_q <= wr_data[DATA_W-2:0];
            if (!fe_view) sm0_q <= wr_data[DATA_W-1];
        end
    end

    always_comb begin
        fe_flag = (fe_q == FE_SET);
        rd_view = {fe_view ? fe_flag : sm0_q, low_q};
    end

endmodule

// File: rtl/uart_baud_frame_ctl.sv
module uart_baud_frame_ctl
    import uart_bfc_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8,
    localparam int RLD_W = 2 * DATA_W
) (
    input  logic                 clk,
    input  logic                 por_n,
    input  logic                 sys_rst_n,
    input  logic                 t1_tick,
    input  logic                 t2_tick,
    input  logic                 gen_tick,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wr_data,
    output logic [DATA_W-1:0]    rd_data,
    input  logic [NUM_PORTS-1:0] fe_pulse,
    output logic [NUM_PORTS-1:0] baud_tick,
    output logic [NUM_PORTS-1:0] ri_late,
    output logic                 gen_run,
    output logic [RLD_W-1:0]     gen_reload
);

    logic                 rst_any;
    logic [DATA_W-1:0]    mode_q, bcfg_q;
    logic [RLD_W-1:0]     reload_q;
    logic                 sel_change;
    logic                 rate_full, fe_view;
    logic                 p0_tick, p1_tick_q;
    logic [DATA_W-1:0]    scon_view [NUM_PORTS];
    logic [NUM_PORTS-1:0] sm0_bits, fe_flag, scon_wr;
    logic [DATA_W-1:0]    rd_nxt, rd_q;

    always_comb begin
        rst_any   = !por_n || !sys_rst_n;
        rate_full = mode_q[DATA_W-1];
        fe_view   = mode_q[DATA_W-2];
    end

    bfc_cfg_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) regs_i (
        .clk        (clk),
        .por_n      (por_n),
        .sys_rst_n  (sys_rst_n),
        .wr_en      (wr_en),
        .addr       (addr),
        .wr_data    (wr_data),
        .mode_q     (mode_q),
        .bcfg_q     (bcfg_q),
        .reload_q   (reload_q),
        .sel_change (sel_change)
    );

    bfc_port0_div div0_i (
        .clk        (clk),
        .rst        (rst_any),
        .t1_tick    (t1_tick),
        .t2_tick    (t2_tick),
        .gen_tick   (gen_tick),
        .sel        (baud_src_e'(bcfg_q[1:0])),
        .sel_change (sel_change),
        .rate_full  (rate_full),
        .tick_q     (p0_tick)
    );

    always_ff @(posedge clk) begin
        if (rst_any) p1_tick_q <= 1'b0;
        else         p1_tick_q <= gen_tick;
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_slot
        always_comb scon_wr[p] = wr_en && (addr == ADDR_W'(int'(REG_SC0) + p));

        bfc_bit7_slot #(.DATA_W(DATA_W)) slot_i (
            .clk      (clk),
            .rst      (rst_any),
            .wr       (scon_wr[p]),
            .wr_data  (wr_data),
            .fe_view  (fe_view),
            .fe_pulse (fe_pulse[p]),
            .rd_view  (scon_view[p]),
            .sm0_q    (sm0_bits[p]),
            .fe_flag  (fe_flag[p])
        );

        always_comb ri_late[p] = fe_view && sm0_bits[p];
    end

    always_comb begin
        unique case (addr)
            ADDR_W'(REG_MODE):  rd_nxt = mode_q;
            ADDR_W'(REG_SC0):   rd_nxt = scon_view[0];
            ADDR_W'(REG_SC1):   rd_nxt = scon_view[1];
            ADDR_W'(REG_BCFG):  rd_nxt = bcfg_q;
            ADDR_W'(REG_RLDLO): rd_nxt = reload_q[DATA_W-1:0];
            ADDR_W'(REG_RLDHI): rd_nxt = reload_q[RLD_W-1:DATA_W];
            default:            rd_nxt = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst_any)    rd_q <= '0;
        else if (rd_en) rd_q <= rd_nxt;
    end

    always_comb begin
        rd_data    = rd_q;
        baud_tick  = {p1_tick_q, p0_tick};
        gen_run    = bcfg_q[2];
        gen_reload = reload_q;
    end

endmodule

// File: rtl/bfc_checker.sv
module bfc_checker #(
    parameter int RLD_W = 16
) (
    input logic             clk,
    input logic             rst_any,
    input logic             t1_tick,
    input logic             t2_tick,
    input logic             gen_tick,
    input logic [1:0]       baud_tick,
    input logic             rate_full,
    input logic             gen_run,
    input logic [RLD_W-1:0] gen_reload,
    input logic [1:0]       fe_pulse,
    input logic [1:0]       fe_flag
);

    logic live_q;

    always_ff @(posedge clk) begin
        if (rst_any) live_q <= 1'b0;
        else         live_q <= 1'b1;
    end

    // R1: a port 0 tick needs some source strobe one cycle earlier
    a_r1_tick_has_source: assert property (@(posedge clk) disable iff (rst_any)
        (live_q && baud_tick[0]) |-> $past(t1_tick || t2_tick || gen_tick));

    // R2: port 1 mirrors the generator with one cycle of delay
    a_r2_port1_follows_gen: assert property (@(posedge clk) disable iff (rst_any)
        live_q |-> (baud_tick[1] == $past(gen_tick)));

    // R3: at half rate no two port 0 ticks are back to back
    a_r3_half_no_pair: assert property (@(posedge clk) disable iff (rst_any)
        (baud_tick[0] && !rate_full) |=> !baud_tick[0]);

    // R6: a framing-error pulse always leaves the flag set
    a_r6_fe_set_p0: assert property (@(posedge clk) disable iff (rst_any)
        (live_q && $past(fe_pulse[0])) |-> fe_flag[0]);

    a_r6_fe_set_p1: assert property (@(posedge clk) disable iff (rst_any)
        (live_q && $past(fe_pulse[1])) |-> fe_flag[1]);

    // R9: the reload value holds while the generator runs
    a_r9_reload_frozen: assert property (@(posedge clk) disable iff (rst_any)
        gen_run |=> $stable(gen_reload));

endmodule

bind uart_baud_frame_ctl bfc_checker #(.RLD_W(RLD_W)) chk_i (
    .clk        (clk),
    .rst_any    (rst_any),
    .t1_tick    (t1_tick),
    .t2_tick    (t2_tick),
    .gen_tick   (gen_tick),
    .baud_tick  (baud_tick),
    .rate_full  (rate_full),
    .gen_run    (gen_run),
    .gen_reload (gen_reload),
    .fe_pulse   (fe_pulse),
    .fe_flag    (fe_flag)
);

// File: tb/uart_baud_frame_ctl_tb_top.sv
module uart_baud_frame_ctl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        por_n = 1'b0, sys_rst_n = 1'b1;
    logic        t1_tick = 1'b0, t2_tick = 1'b0, gen_tick = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_data;
    logic [1:0]  fe_pulse = '0;
    logic [1:0]  baud_tick, ri_late;
    logic        gen_run;
    logic [15:0] gen_reload;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_baud_frame_ctl dut_i (
        .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n),
        .t1_tick(t1_tick), .t2_tick(t2_tick), .gen_tick(gen_tick),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .fe_pulse(fe_pulse), .baud_tick(baud_tick),
        .ri_late(ri_late), .gen_run(gen_run), .gen_reload(gen_reload)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk); rd_en = 1'b1; addr = a;
        @(negedge clk); rd_en = 1'b0; d = rd_data;
    endtask

    task automatic strobe(input int src, input int n, output int c0, output int c1);
        c0 = 0; c1 = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (src == 0) t1_tick = 1'b1;
            else if (src == 1) t2_tick = 1'b1;
            else gen_tick = 1'b1;
            @(negedge clk);
            t1_tick = 1'b0; t2_tick = 1'b0; gen_tick = 1'b0;
            c0 += int'(baud_tick[0]); c1 += int'(baud_tick[1]);
        end
    endtask

    task automatic t_reset_values();
        logic [7:0] d;
        chk("R10 ticks after reset", baud_tick, 0);
        chk("R10 reload after reset", gen_reload, 0);
        chk("R10 run after reset", gen_run, 0);
        rd(3'd0, d); chk("R10 mode after power-on", d, 8'h10);
        rd(3'd1, d); chk("R10 sc0 after power-on", d, 8'h00);
        wr(3'd0, 8'hC5); wr(3'd1, 8'h3C);
        @(negedge clk); sys_rst_n = 1'b0;
        @(negedge clk); sys_rst_n = 1'b1;
        rd(3'd0, d); chk("R10 mode after system reset", d, 8'h00);
        rd(3'd1, d); chk("R10 sc0 after system reset", d, 8'h00);
    endtask

    task automatic t_latency();
        logic [7:0] d;
        wr(3'd0, 8'h80); wr(3'd3, 8'h00);
        @(negedge clk); t1_tick = 1'b1;
        #1 chk("R11 no tick before edge", baud_tick[0], 0);
        @(negedge clk); t1_tick = 1'b0;
        chk("R11 tick one edge later", baud_tick[0], 1);
        @(negedge clk); chk("R11 tick lasts one cycle", baud_tick[0], 0);
        @(negedge clk); rd_en = 1'b1; addr = 3'd0;
        #1 chk("R11 read data not early", rd_data, 8'h00);
        @(negedge clk); rd_en = 1'b0;
        chk("R11 read data one edge later", rd_data, 8'h80);
        rd(3'd6, d); chk("R11 unused address reads zero", d, 0);
    endtask

    task automatic t_sources();
        int c0, c1;
        wr(3'd0, 8'h00); wr(3'd3, 8'h00);
        strobe(0, 4, c0, c1); chk("R3 half rate Timer 1", c0, 2);
        strobe(1, 4, c0, c1); chk("R1 Timer 2 ignored when Timer 1 selected", c0, 0);
        strobe(2, 4, c0, c1); chk("R1 generator ignored when Timer 1 selected", c0, 0);
        chk("R2 port 1 at half setting", c1, 4);
        wr(3'd0, 8'h80);
        strobe(0, 4, c0, c1); chk("R3 full rate Timer 1", c0, 4);
        wr(3'd3, 8'h01);
        strobe(1, 3, c0, c1); chk("R1 Timer 2 selected full rate", c0, 3);
        strobe(0, 3, c0, c1); chk("R1 Timer 1 ignored when Timer 2 selected", c0, 0);
        wr(3'd0, 8'h00); wr(3'd3, 8'h02);
        strobe(2, 4, c0, c1); chk("R3 half rate generator", c0, 2);
        chk("R2 port 1 every generator tick", c1, 4);
        wr(3'd3, 8'h03);
        strobe(2, 2, c0, c1); chk("R1 code 11 selects generator", c0, 1);
    endtask

    task automatic t_phase_restart();
        int c0, c1;
        wr(3'd0, 8'h00); wr(3'd3, 8'h00);
        strobe(0, 1, c0, c1); chk("R4 first tick skipped", c0, 0);
        wr(3'd3, 8'h01);
        strobe(1, 1, c0, c1); chk("R4 phase restarted on select change", c0, 0);
        strobe(1, 1, c0, c1); chk("R4 second tick after change passes", c0, 1);
    endtask

    task automatic t_bit7_slots();
        logic [7:0] d;
        wr(3'd0, 8'h00);
        wr(3'd1, 8'hC3); rd(3'd1, d); chk("R5 sc0 mode bit stored", d, 8'hC3);
        @(negedge clk); fe_pulse = 2'b01; @(negedge clk); fe_pulse = 2'b00;
        rd(3'd1, d); chk("R5 flag hidden while view off", d, 8'hC3);
        wr(3'd0, 8'h40);
        rd(3'd1, d); chk("R6 flag visible", d, 8'hC3);
        chk("R8 ri_late port 0", ri_late[0], 1);
        chk("R8 ri_late port 1 mode bit 0", ri_late[1], 0);
        wr(3'd1, 8'h43); rd(3'd1, d); chk("R6 write 0 clears flag", d, 8'h43);
        wr(3'd1, 8'hC3); rd(3'd1, d); chk("R6 write 1 does not set flag", d, 8'h43);
        wr(3'd0, 8'h00);
        rd(3'd1, d); chk("R7 mode bit kept across view change", d, 8'hC3);
        chk("R8 ri_late off with view off", ri_late[0], 0);
        @(negedge clk); fe_pulse = 2'b01; @(negedge clk); fe_pulse = 2'b00;
        wr(3'd1, 8'h03);
        wr(3'd0, 8'h40);
        rd(3'd1, d); chk("R7 flag kept while mode bit written", d, 8'h83);
        rd(3'd2, d); chk("R6 port 1 flag untouched by port 0 pulse", d, 8'h00);
        @(negedge clk); wr_en = 1'b1; addr = 3'd1; wr_data = 8'h03; fe_pulse = 2'b01;
        @(negedge clk); wr_en = 1'b0; fe_pulse = 2'b00;
        rd(3'd1, d); chk("R12 pulse wins over clear", d, 8'h83);
        wr(3'd0, 8'h00); wr(3'd2, 8'h80); wr(3'd0, 8'h40);
        chk("R8 ri_late port 1", ri_late[1], 1);
        wr(3'd0, 8'h00);
    endtask

    task automatic t_reload_lock();
        logic [7:0] d;
        wr(3'd3, 8'h00);
        wr(3'd4, 8'h34); wr(3'd5, 8'h12);
        chk("R9 reload written while stopped", gen_reload, 16'h1234);
        wr(3'd3, 8'h04);
        chk("R9 run bit", gen_run, 1);
        wr(3'd4, 8'hFF); wr(3'd5, 8'hEE);
        chk("R9 reload frozen while running", gen_reload, 16'h1234);
        rd(3'd4, d); chk("R9 low byte read back", d, 8'h34);
        wr(3'd3, 8'h00);
        wr(3'd4, 8'hFF);
        chk("R9 reload writable again", gen_reload, 16'h12FF);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
        t_reset_values();
        t_latency();
        t_sources();
        t_phase_restart();
        t_bit7_slots();
        t_reload_lock();
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

endmodule